// File: doc/BRIEF.md
# 64-Point Two-Pass FFT Processor

This block computes a 64-point complex discrete Fourier transform, or its inverse, on fixed-point data. The 64 bins are treated as an 8-by-8 grid. The input index is k = l + 8m and the output index is r = s + 8t, with l, m, s and t each in 0..7. The first pass runs eight 8-point transforms. Each one gathers the eight samples that share the same l. Every intermediate value is then multiplied by the twiddle W64^(l·s), and the result is written back into the working memory. The second pass runs eight more 8-point transforms on consecutive groups. Reading the results out in transposed order returns the spectrum in natural frequency order.

The block has one 8-point engine that is shared in time and needs no general multiplier. Its odd rotations use a constant 1/√2 factor. The block also holds a 64-entry working memory, a twiddle table generated from a quarter-wave cosine, and one complex multiplier. Samples enter on a valid/ready stream, and results leave as a 64-cycle burst qualified by a valid flag. A mode input selects the inverse. That mode conjugates both the twiddles and the engine rotations.

Each pass scales by 1/8 with round-half-up, so both directions carry an overall factor of 1/64. The inverse gets no normalisation beyond this.

Top module: `fft64_two_pass`

## Requirements
- R1: After reset, and between frames, `inReady` is 1. A sample is taken when `inValid` and `inReady` are both 1. The n-th sample taken in a frame is x[n] for n = 0..63, with the real part on `inRe` and the imaginary part on `inIm`, both two's complement.
- R2: With `inverse` = 0, output r equals (1/64)·Σk x[k]·e^(−j2πkr/64). Each part is within 3 LSB of the exact value, for inputs of magnitude up to 8000 per part.
- R3: With `inverse` = 1, output r equals (1/64)·Σk x[k]·e^(+j2πkr/64), within the same tolerance. The mode is sampled together with sample x[0] only. Its value during samples x[1]..x[63] has no effect.
- R4: The 64 results appear in the order r = 0, 1, …, 63, on 64 consecutive cycles with `outValid` = 1.
- R5: Count the cycle in which x[63] is accepted as cycle 0. Then `outValid` first goes high in cycle 258.
- R6: `inReady` is 0 from the cycle after x[63] is accepted through the cycle that carries the last result. Any `inValid` pulse in that window is ignored and does not disturb the frame in flight.
- R7: `busy` is 0 when idle. It is 1 from the cycle after x[0] is accepted through the cycle that carries the last result, and 0 in the cycle after that.
- R8: Results are DATA_W+1 bits wide, so a full-scale input never wraps. A constant frame with every sample equal to c yields exactly c at r = 0 and 0 at every other bin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample is valid |
| inReady | output | 1 | Block accepts a sample this cycle |
| inverse | input | 1 | 1 selects the inverse transform; sampled with x[0] |
| inRe | input | DATA_W | Input sample, real part |
| inIm | input | DATA_W | Input sample, imaginary part |
| outValid | output | 1 | Result valid |
| outRe | output | DATA_W+1 | Result, real part |
| outIm | output | DATA_W+1 | Result, imaginary part |
| busy | output | 1 | A frame is being loaded, computed or drained |

## Verification
A wrong memory address or a transposition slip in either pass shows up as misplaced energy. Single impulses catch it plainly: the spectrum of an impulse must have flat magnitude and a phase slope. The error is visible on the first result burst, 258 cycles after the frame closes. A sign error in a rotation or a twiddle, or a mode latched on the wrong sample, changes the phase direction. An impulse at k = 1 in inverse mode exposes it at bin 1 onward. A scheduling fault in the control shifts the start of the output burst, breaks its continuity or moves the falling edge of `busy`. Each of these is measured in cycles against the expected numbers.

// File: rtl/fft64_pkg.sv
package fft64_pkg;
  localparam int PTS   = 8;
  localparam int NPT   = PTS * PTS;
  localparam int IDXW  = $clog2(PTS);
  localparam int ADDRW = $clog2(NPT);
  localparam int TWQ   = 14;

  typedef struct packed {
    logic             load;
    logic             gather;
    logic             emit;
    logic             drain;
    logic             pass2;
    logic             inv;
    logic [IDXW-1:0]  slot;
    logic [ADDRW-1:0] addr;
    logic [ADDRW-1:0] twExp;
  } fftCtrlT;

  // cos(2*pi*i/64) in Q14 for the first quadrant, i = 0..16
  function automatic logic signed [15:0] cosQuarter(input logic [4:0] i);
    case (i)
      5'd0:  return 16'sd16384;
      5'd1:  return 16'sd16305;
      5'd2:  return 16'sd16069;
      5'd3:  return 16'sd15679;
      5'd4:  return 16'sd15137;
      5'd5:  return 16'sd14449;
      5'd6:  return 16'sd13623;
      5'd7:  return 16'sd12665;
      5'd8:  return 16'sd11585;
      5'd9:  return 16'sd10394;
      5'd10: return 16'sd9102;
      5'd11: return 16'sd7723;
      5'd12: return 16'sd6270;
      5'd13: return 16'sd4756;
      5'd14: return 16'sd3196;
      5'd15: return 16'sd1606;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [15:0] cos64(input logic [5:0] p);
    logic [4:0] i;
    i = {1'b0, p[3:0]};
    case (p[5:4])
      2'd0: return cosQuarter(i);
      2'd1: return -cosQuarter(5'd16 - i);
      2'd2: return -cosQuarter(i);
      default: return cosQuarter(5'd16 - i);
    endcase
  endfunction

  function automatic logic signed [15:0] sin64(input logic [5:0] p);
    return cos64(p - 6'd16);
  endfunction
endpackage

// File: rtl/fft_engine8.sv
module fft_engine8
  import fft64_pkg::*;
#(
  parameter int W = 17
) (
  input  logic [PTS-1:0][W-1:0] xRe,
  input  logic [PTS-1:0][W-1:0] xIm,
  input  logic [IDXW-1:0]       slot,
  input  logic                  inv,
  output logic signed [W-1:0]   yRe,
  output logic signed [W-1:0]   yIm
);
  localparam int FRAC = 8;
  localparam int RSH  = 16 - FRAC;
  localparam int AW   = W + 26;
  typedef logic signed [AW-1:0] accT;
  localparam accT RSQ2 = 46341;  // 1/sqrt(2) in Q16
  localparam accT HALF = accT'(1) <<< (FRAC + IDXW - 1);

  accT accRe, accIm, a, b, tr, ti;
  logic [IDXW-1:0] n;

  // one output bin per cycle: y[slot] = sum_m x[m] * W8^(m*slot)
  always_comb begin
    accRe = '0;
    accIm = '0;
    a = '0; b = '0; tr = '0; ti = '0; n = '0;
    for (int m = 0; m < PTS; m++) begin
      a = accT'(signed'(xRe[m]));
      b = accT'(signed'(xIm[m]));
      n = IDXW'(m * int'(slot));
      if (inv) n = -n;
      case (n)
        3'd0: begin tr = a <<< FRAC;               ti = b <<< FRAC;               end
        3'd1: begin tr = ((a + b) * RSQ2) >>> RSH; ti = ((b - a) * RSQ2) >>> RSH; end
        3'd2: begin tr = b <<< FRAC;               ti = -(a <<< FRAC);            end
        3'd3: begin tr = ((b - a) * RSQ2) >>> RSH; ti = (-(a + b) * RSQ2) >>> RSH; end
        3'd4: begin tr = -(a <<< FRAC);            ti = -(b <<< FRAC);            end
        3'd5: begin tr = (-(a + b) * RSQ2) >>> RSH; ti = ((a - b) * RSQ2) >>> RSH; end
        3'd6: begin tr = -(b <<< FRAC);            ti = a <<< FRAC;               end
        default: begin tr = ((a - b) * RSQ2) >>> RSH; ti = ((a + b) * RSQ2) >>> RSH; end
      endcase
      accRe = accRe + tr;
      accIm = accIm + ti;
    end
  end

  // scale by 1/8 with round-half-up
  assign yRe = W'((accRe + HALF) >>> (FRAC + IDXW));
  assign yIm = W'((accIm + HALF) >>> (FRAC + IDXW));
endmodule

// File: rtl/fft_twiddle.sv
module fft_twiddle
  import fft64_pkg::*;
#(
  parameter int W = 17
) (
  input  logic signed [W-1:0]   aRe,
  input  logic signed [W-1:0]   aIm,
  input  logic [ADDRW-1:0]      expo,
  input  logic                  inv,
  output logic signed [W-1:0]   pRe,
  output logic signed [W-1:0]   pIm
);
  localparam int PW = W + 18;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (TWQ - 1);

  logic signed [15:0] cVal, sVal, dVal;
  logic signed [PW-1:0] prodRe, prodIm;

  always_comb begin
    cVal = cos64(expo);
    sVal = sin64(expo);
    dVal = inv ? sVal : -sVal;
    prodRe = PW'(aRe) * PW'(cVal) - PW'(aIm) * PW'(dVal);
    prodIm = PW'(aRe) * PW'(dVal) + PW'(aIm) * PW'(cVal);
  end

  assign pRe = W'((prodRe + RND) >>> TWQ);
  assign pIm = W'((prodIm + RND) >>> TWQ);
endmodule

// File: rtl/fft_ctrl.sv
module fft_ctrl
  import fft64_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  input  logic    inverse,
  output logic    inReady,
  output logic    outValid,
  output logic    busy,
  output fftCtrlT str
);
  typedef enum logic [1:0] {ST_LOAD, ST_GATHER, ST_EMIT, ST_DRAIN} stateT;

  stateT            state;
  logic             pass2, inv, validQ;
  logic [IDXW-1:0]  grp, slot;
  logic [ADDRW-1:0] loadCnt, outIdx;
  logic             take;

  assign inReady  = (state == ST_LOAD) && !validQ;
  assign take     = inValid && inReady;
  assign outValid = validQ;
  assign busy     = (state != ST_LOAD) || (loadCnt != '0) || validQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_LOAD;
      pass2   <= 1'b0;
      inv     <= 1'b0;
      validQ  <= 1'b0;
      grp     <= '0;
      slot    <= '0;
      loadCnt <= '0;
      outIdx  <= '0;
    end else begin
      validQ <= (state == ST_DRAIN);
      case (state)
        ST_LOAD: if (take) begin
          if (loadCnt == '0) inv <= inverse;
          loadCnt <= loadCnt + 1'b1;
          if (loadCnt == ADDRW'(NPT - 1)) begin
            state <= ST_GATHER;
            pass2 <= 1'b0;
            grp   <= '0;
            slot  <= '0;
          end
        end
        ST_GATHER: begin
          slot <= slot + 1'b1;
          if (slot == IDXW'(PTS - 1)) state <= ST_EMIT;
        end
        ST_EMIT: begin
          slot <= slot + 1'b1;
          if (slot == IDXW'(PTS - 1)) begin
            grp <= grp + 1'b1;
            if (grp == IDXW'(PTS - 1)) begin
              if (pass2) begin
                state  <= ST_DRAIN;
                outIdx <= '0;
              end else begin
                pass2 <= 1'b1;
                state <= ST_GATHER;
              end
            end else begin
              state <= ST_GATHER;
            end
          end
        end
        default: begin
          outIdx <= outIdx + 1'b1;
          if (outIdx == ADDRW'(NPT - 1)) state <= ST_LOAD;
        end
      endcase
    end
  end

  always_comb begin
    str        = '0;
    str.load   = (state == ST_LOAD) && take;
    str.gather = (state == ST_GATHER);
    str.emit   = (state == ST_EMIT);
    str.drain  = (state == ST_DRAIN);
    str.pass2  = pass2;
    str.inv    = inv;
    str.slot   = slot;
    str.twExp  = ADDRW'(grp) * ADDRW'(slot);
    case (state)
      ST_LOAD:  str.addr = loadCnt;
      ST_DRAIN: str.addr = {outIdx[IDXW-1:0], outIdx[ADDRW-1:IDXW]};
      default:  str.addr = pass2 ? {grp, slot} : {slot, grp};
    endcase
  end

  // R6: the frame closes on the 64th sample
  p_frame_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && loadCnt == ADDRW'(NPT - 1)) |=> !inReady);
  // R3: mode only changes while loading
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_LOAD) |=> (inv == $past(inv)));
  // R4: the drain burst is unbroken
  p_drain_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && outIdx != ADDRW'(NPT - 1)) |=> (state == ST_DRAIN));
endmodule

// File: rtl/fft_datapath.sv
module fft_datapath
  import fft64_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fftCtrlT             str,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic signed [DATA_W:0]   outRe,
  output logic signed [DATA_W:0]   outIm
);
  localparam int MW = DATA_W + 1;

  logic signed [MW-1:0] memRe [NPT];
  logic signed [MW-1:0] memIm [NPT];
  logic [PTS-1:0][MW-1:0] engRe, engIm;
  logic signed [MW-1:0] rdRe, rdIm, yRe, yIm, twRe, twIm, wrRe, wrIm;

  assign rdRe = memRe[str.addr];
  assign rdIm = memIm[str.addr];

  fft_engine8 #(.W(MW)) u_engine (
    .xRe(engRe), .xIm(engIm), .slot(str.slot), .inv(str.inv),
    .yRe(yRe), .yIm(yIm)
  );

  fft_twiddle #(.W(MW)) u_twiddle (
    .aRe(yRe), .aIm(yIm), .expo(str.twExp), .inv(str.inv),
    .pRe(twRe), .pIm(twIm)
  );

  assign wrRe = str.pass2 ? yRe : twRe;
  assign wrIm = str.pass2 ? yIm : twIm;

  always_ff @(posedge clk) begin
    if (str.load) begin
      memRe[str.addr] <= MW'(inRe);
      memIm[str.addr] <= MW'(inIm);
    end else if (str.emit) begin
      memRe[str.addr] <= wrRe;
      memIm[str.addr] <= wrIm;
    end
    if (str.gather) begin
      engRe[str.slot] <= rdRe;
      engIm[str.slot] <= rdIm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outRe <= '0;
      outIm <= '0;
    end else if (str.drain) begin
      outRe <= rdRe;
      outIm <= rdIm;
    end
  end

  // R5: single-port schedule, one phase at a time
  p_phase_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({str.load, str.gather, str.emit, str.drain}));
  // R5: emission always follows a full gather of the same group
  p_emit_after_gather_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(str.emit) |-> $past(str.gather));
endmodule

// File: rtl/fft64_two_pass.sv
module fft64_two_pass
  import fft64_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic                     inverse,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outValid,
  output logic signed [DATA_W:0]   outRe,
  output logic signed [DATA_W:0]   outIm,
  output logic                     busy
);
  fftCtrlT str;

  fft_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inverse(inverse),
    .inReady(inReady), .outValid(outValid), .busy(busy), .str(str)
  );

  fft_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rst_n(rst_n), .str(str), .inRe(inRe), .inIm(inIm),
    .outRe(outRe), .outIm(outIm)
  );

  // R7: busy only drops right after the last result
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(outValid));
endmodule

// File: tb/tb_fft64_two_pass.sv
module tb_fft64_two_pass;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inverse = 1'b0;
  logic signed [15:0] inRe = '0, inIm = '0;
  logic inReady, outValid, busy;
  logic signed [16:0] outRe, outIm;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  int sRe [64];
  int sIm [64];
  real eRe [64];
  real eIm [64];

  always #10 clk = ~clk;

  fft64_two_pass dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inverse(inverse), .inRe(inRe), .inIm(inIm), .outValid(outValid),
    .outRe(outRe), .outIm(outIm), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic refDft(input bit inv);
    for (int r = 0; r < 64; r++) begin
      real ar, ai, th, sg;
      ar = 0.0; ai = 0.0;
      sg = inv ? -1.0 : 1.0;
      for (int k = 0; k < 64; k++) begin
        th = 2.0 * 3.14159265358979 * real'(k * r) / 64.0;
        ar += real'(sRe[k]) * $cos(th) + sg * real'(sIm[k]) * $sin(th);
        ai += real'(sIm[k]) * $cos(th) - sg * real'(sRe[k]) * $sin(th);
      end
      eRe[r] = ar / 64.0;
      eIm[r] = ai / 64.0;
    end
  endtask

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic runFrame(input bit inv, input bit gaps, input bit garbage, input string req);
    int k, cnt;
    bit b0, b1, readyBad, contBad;
    refDft(inv);
    k = 0; b0 = 0; b1 = 0;
    while (k < 64) begin
      @(negedge clk);
      if (k == 0 && !b0) begin
        chk(!busy, "R7", $sformatf("busy before frame act=%0b exp=0", busy)); b0 = 1;
      end
      if (k == 1 && !b1) begin
        chk(busy, "R7", $sformatf("busy after first sample act=%0b exp=1", busy)); b1 = 1;
      end
      if (gaps && $urandom_range(3) == 0) inValid = 1'b0;
      else begin
        inValid = 1'b1;
        inRe = 16'(sRe[k]);
        inIm = 16'(sIm[k]);
        inverse = (k == 0) ? inv : ~inv;  // R3: later samples carry the other mode
      end
      if (inValid && inReady) k++;
    end
    cnt = 0; readyBad = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (inReady || !busy) readyBad = 1;
      inValid = garbage;
      inRe = 16'($urandom);
      inIm = 16'($urandom);
      inverse = ~inverse;
    end while (!outValid && cnt < 2000);
    chk(cnt == 258, "R5", $sformatf("latency act=%0d exp=258", cnt));
    contBad = 0;
    for (int r = 0; r < 64; r++) begin
      real dr, di;
      if (!outValid) contBad = 1;
      if (inReady || !busy) readyBad = 1;
      dr = absr(real'(outRe) - eRe[r]);
      di = absr(real'(outIm) - eIm[r]);
      chk(dr <= 3.0 && di <= 3.0, req, $sformatf("bin %0d act=(%0d,%0d) exp=(%f,%f)",
          r, outRe, outIm, eRe[r], eIm[r]));
      @(negedge clk);
    end
    inValid = 1'b0;
    chk(!readyBad, "R6", $sformatf("inReady/busy during processing act=%0b exp=0", readyBad));
    chk(!contBad, "R4", $sformatf("output burst gap act=%0b exp=0", contBad));
    chk(!outValid && !busy && inReady, "R7",
        $sformatf("after burst outValid=%0b busy=%0b inReady=%0b exp=0,0,1", outValid, busy, inReady));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!outValid && !busy, "R7", $sformatf("reset outValid=%0b busy=%0b exp=0,0", outValid, busy));
    rst_n = 1'b1;
    @(negedge clk);
    chk(inReady, "R1", $sformatf("idle inReady act=%0b exp=1", inReady));

    // impulse at k=0: flat spectrum
    for (int k = 0; k < 64; k++) begin sRe[k] = 0; sIm[k] = 0; end
    sRe[0] = 6400;
    runFrame(1'b0, 1'b0, 1'b0, "R2");
    // shifted complex impulse: phase slope, checks R1 sample order
    for (int k = 0; k < 64; k++) begin sRe[k] = 0; sIm[k] = 0; end
    sRe[5] = 6400; sIm[5] = -3200;
    runFrame(1'b0, 1'b1, 1'b0, "R2");
    // full-scale constant: R8 no wrap
    for (int k = 0; k < 64; k++) begin sRe[k] = 32767; sIm[k] = -32768; end
    refDft(1'b0);
    runFrame(1'b0, 1'b0, 1'b1, "R8");
    // random forward with gaps and ignored inValid (R6)
    for (int k = 0; k < 64; k++) begin
      sRe[k] = int'($urandom_range(16000)) - 8000;
      sIm[k] = int'($urandom_range(16000)) - 8000;
    end
    runFrame(1'b0, 1'b1, 1'b1, "R2");
    // impulse at k=1 inverse: opposite rotation
    for (int k = 0; k < 64; k++) begin sRe[k] = 0; sIm[k] = 0; end
    sRe[1] = 6400;
    runFrame(1'b1, 1'b0, 1'b0, "R3");
    // random inverse
    for (int k = 0; k < 64; k++) begin
      sRe[k] = int'($urandom_range(16000)) - 8000;
      sIm[k] = int'($urandom_range(16000)) - 8000;
    end
    runFrame(1'b1, 1'b1, 1'b1, "R3");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run hung act=timeout exp=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule